// File: doc/BRIEF.md
# Twelve-Channel Converter Code Bank with Two-Wire Write Slave

This block is a write-only I2C target that holds twelve 8-bit output codes. Each code would drive an external resistor-ladder converter. A system clock oversamples the bus lines, and a digital filter removes short glitches from both of them. The block acknowledges writes sent to its 7-bit address. The upper four bits of that address are a fixed pattern. The lower three bits come from strap inputs, so up to eight of these blocks can share one bus. After the address byte, the controller sends one selector byte and then one or more code bytes. The block presents all twelve codes at once on one wide output bus. It drives the bus data line only through an open-drain enable, `sda_oe`.

The low nibble of the selector byte picks one of three actions:
- a single channel;
- a broadcast, in which one code is copied into every channel;
- an auto-increment stream, which walks channels 1 to 12 and wraps around until the next START or STOP.

The output code maps linearly to the analog level. Code 00 is the bottom of the range and code FF is 255/256 of full scale. That mapping happens outside this block.

The frame state machine has eight states:
- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: receiving the address byte.
- `ST_ADDR_ACK`: driving the address acknowledge.
- `ST_CHAN`: receiving the selector byte.
- `ST_CHAN_ACK`: driving the selector acknowledge.
- `ST_DATA`: receiving a code byte.
- `ST_DATA_ACK`: driving the code acknowledge. The register write happens on entry to this state.
- `ST_IGNORE`: deaf until the next START.

Transitions:
- A STOP from any state goes to `ST_IDLE`. A START from any state goes to `ST_ADDR`.
- After the eighth falling SCL edge, `ST_ADDR` goes to `ST_ADDR_ACK` on an address match with a write bit. It goes to `ST_IGNORE` otherwise.
- On the eighth falling edge, `ST_CHAN` goes to `ST_CHAN_ACK` and `ST_DATA` goes to `ST_DATA_ACK`.
- On the next falling edge, each acknowledge state moves on: `ST_ADDR_ACK` to `ST_CHAN`, `ST_CHAN_ACK` to `ST_DATA`, and `ST_DATA_ACK` back to `ST_DATA`.

Top module: `i2c_dac_regbank`

## Requirements
- R1: After an active-low reset, every channel code reads 00 and `sda_oe` is low.
- R2: The block acknowledges an address byte whose upper seven bits equal binary 1001 followed by `addr_strap[2:0]` and whose last (R/W) bit is 0. It asserts `sda_oe` while SCL is high during the ninth clock of that byte. It acknowledges every later byte of the same frame the same way.
- R3: The block does not acknowledge an address byte that does not match, or that has R/W = 1. After such a byte it acknowledges nothing and changes no code until the next START.
- R4: A selector byte whose low nibble is 1 to 12 targets channel (nibble); channel 1 is `code_out[7:0]` and channel n is `code_out[8n-1:8n-8]`. The upper nibble has no effect.
- R5: After a single-channel selector, the first code byte loads the channel. Further code bytes in the same frame are acknowledged and change nothing.
- R6: Selector low nibble 0 loads the first following code byte into all twelve channels. Later bytes in that frame are acknowledged and change nothing.
- R7: Selector low nibble F loads successive code bytes into channels 1, 2, … 12, then wraps back to channel 1.
- R8: Selector low nibbles D and E are acknowledged, as are the code bytes after them, but no channel changes.
- R9: A channel's code changes after the eighth falling SCL edge of its code byte and before SCL rises for that byte's acknowledge clock.
- R10: The block ignores a pulse on SCL or SDA that is shorter than `FILT_CYC` system clocks. Such a pulse does not count as a bit, a START or a STOP.
- R11: A repeated START or a STOP ends a stream. A new auto-increment stream starts again at channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| addr_strap | input | 3 | Low three address bits |
| sda_oe | output | 1 | Pull data line low when 1 (acknowledge) |
| code_out | output | 96 | Twelve 8-bit codes, channel 1 in the low byte |

## Verification
A wrong bit count or a wrong filter decision shows up on `sda_oe` within one byte. The acknowledge then lands on the wrong clock, or is missing when it should be present, and it is sampled on every ninth clock. A wrong selector mode or a wrong stream pointer shows up on `code_out` at the acknowledge of the first affected code byte: the wrong channel changes, or an extra channel changes. Sweeping every channel, every strap value and the special selector codes exposes each of these within a frame. A state machine left deaf or stuck across a START shows up as a missing acknowledge on the very next address byte.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CHAN,
        ST_CHAN_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } frame_state_t;

    typedef enum logic [1:0] {
        WM_NONE,
        WM_ONE,
        WM_ALL,
        WM_SEQ
    } wr_mode_t;

    localparam logic [3:0] SEL_BCAST  = 4'h0;
    localparam logic [3:0] SEL_STREAM = 4'hF;

endpackage

// File: rtl/dac_pin_filter.sv
module dac_pin_filter #(
    parameter int STABLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_clean
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic       meta_q, sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= pin_raw;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_clean <= 1'b1;
            run_q     <= '0;
        end else if (sync_q == pin_clean) begin
            run_q <= '0;
        end else if (run_q == CW'(STABLE_CYC - 1)) begin
            pin_clean <= sync_q;
            run_q     <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R10: the clean level only moves to a value the synchronised pin held
    a_r10_clean_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_clean != $past(pin_clean)) |-> ($past(sync_q) == pin_clean));

endmodule

// File: rtl/dac_bus_sampler.sv
module dac_bus_sampler #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] raw_pins;
    logic [1:0] clean_pins;
    logic       scl_p, sda_p;

    assign raw_pins = {scl_in, sda_in};

    generate
        for (genvar p = 0; p < 2; p++) begin : g_pin
            dac_pin_filter #(.STABLE_CYC(FILT_CYC)) u_filt (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_raw  (raw_pins[p]),
                .pin_clean(clean_pins[p])
            );
        end
    endgenerate

    assign scl_lvl = clean_pins[1];
    assign sda_lvl = clean_pins[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_lvl;
            sda_p <= sda_lvl;
        end
    end

    assign scl_rise = scl_lvl & ~scl_p;
    assign scl_fall = ~scl_lvl & scl_p;
    assign start_ev = scl_lvl & scl_p & sda_p & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_p & ~sda_p & sda_lvl;

endmodule

// File: rtl/dac_frame_fsm.sv
module dac_frame_fsm
    import dacbank_pkg::*;
#(
    parameter int         NCH     = 12,
    parameter logic [3:0] ADDR_HI = 4'b1001,
    localparam int        IDXW    = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      addr_strap,
    input  logic            scl_lvl,
    input  logic            sda_lvl,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_ev,
    input  logic            stop_ev,
    output logic            sda_oe,
    output logic            wr_en,
    output logic            wr_all,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data
);
    frame_state_t state_q, state_d;
    wr_mode_t     mode_q;
    logic [3:0]   bit_cnt_q;
    logic [7:0]   shift_q;
    logic [IDXW-1:0] sel_q, ptr_q;
    logic         byte_done, receiving, in_ack, addr_hit;
    logic [3:0]   nib, nib_m1;

    assign receiving = (state_q == ST_ADDR) || (state_q == ST_CHAN) || (state_q == ST_DATA);
    assign in_ack    = (state_q == ST_ADDR_ACK) || (state_q == ST_CHAN_ACK) || (state_q == ST_DATA_ACK);
    assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
    assign addr_hit  = (shift_q == {ADDR_HI, addr_strap, 1'b0});
    assign nib       = shift_q[3:0];
    assign nib_m1    = nib - 4'd1;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_d = ST_CHAN;
                ST_CHAN:     if (byte_done) state_d = ST_CHAN_ACK;
                ST_CHAN_ACK: if (scl_fall)  state_d = ST_DATA;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_d = ST_DATA;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        sda_oe = in_ack;
    end

    // byte datapath and write requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            mode_q    <= WM_NONE;
            sel_q     <= '0;
            ptr_q     <= '0;
            wr_en     <= 1'b0;
            wr_all    <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en  <= 1'b0;
            wr_all <= 1'b0;
            if (start_ev || stop_ev) begin
                bit_cnt_q <= '0;
                mode_q    <= WM_NONE;
                ptr_q     <= '0;
            end else if (scl_rise && receiving) begin
                shift_q   <= {shift_q[6:0], sda_lvl};
                bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && in_ack) begin
                bit_cnt_q <= '0;
            end

            if (!start_ev && !stop_ev && byte_done && state_q == ST_CHAN) begin
                ptr_q <= '0;
                sel_q <= nib_m1[IDXW-1:0];
                if (nib == SEL_BCAST)                 mode_q <= WM_ALL;
                else if (nib == SEL_STREAM)           mode_q <= WM_SEQ;
                else if (nib <= 4'(NCH))              mode_q <= WM_ONE;
                else                                  mode_q <= WM_NONE;
            end

            if (!start_ev && !stop_ev && byte_done && state_q == ST_DATA) begin
                wr_data <= shift_q;
                unique case (mode_q)
                    WM_NONE: ;
                    WM_ONE: begin
                        wr_en  <= 1'b1;
                        wr_idx <= sel_q;
                        mode_q <= WM_NONE;
                    end
                    WM_ALL: begin
                        wr_en  <= 1'b1;
                        wr_all <= 1'b1;
                        mode_q <= WM_NONE;
                    end
                    WM_SEQ: begin
                        wr_en  <= 1'b1;
                        wr_idx <= ptr_q;
                        ptr_q  <= (ptr_q == IDXW'(NCH - 1)) ? '0 : ptr_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: acknowledge only ever starts while the clean clock is low
    a_r2_ack_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R3: once deaf, stay deaf until a START
    a_r3_deaf_until_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && !start_ev && !stop_ev) |=> (state_q == ST_IGNORE));

    // R6: a broadcast write closes the broadcast mode in the same cycle
    a_r6_bcast_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_all) |-> (mode_q == WM_NONE));

    // R7: stream pointer always addresses a real channel
    a_r7_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < IDXW'(NCH));

    // R9: a write request only follows the end of a code byte
    a_r9_write_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state_q == ST_DATA_ACK));

endmodule

// File: rtl/dac_code_bank.sv
module dac_code_bank #(
    parameter int  NCH  = 12,
    localparam int IDXW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_all,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [7:0]      wr_data,
    output logic [NCH*8-1:0] code_out
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic [7:0] code_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    code_q <= 8'h00;
                else if (wr_en && (wr_all || wr_idx == IDXW'(c)))
                    code_q <= wr_data;
            end
            assign code_out[c*8 +: 8] = code_q;
        end
    endgenerate

    // R9: codes hold whenever no write request arrives
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(code_out));

    // R6: a broadcast leaves every channel equal to the written byte
    a_r6_bcast_fills_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_all) |=> (code_out == {NCH{$past(wr_data)}}));

endmodule

// File: rtl/i2c_dac_regbank.sv
module i2c_dac_regbank #(
    parameter int         NCH      = 12,
    parameter int         FILT_CYC = 16,
    parameter logic [3:0] ADDR_HI  = 4'b1001,
    localparam int        IDXW     = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [2:0]       addr_strap,
    output logic             sda_oe,
    output logic [NCH*8-1:0] code_out
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_en, wr_all;
    logic [IDXW-1:0] wr_idx;
    logic [7:0] wr_data;

    dac_bus_sampler #(.FILT_CYC(FILT_CYC)) u_smp (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .scl_lvl (scl_lvl),
        .sda_lvl (sda_lvl),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    dac_frame_fsm #(.NCH(NCH), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_strap(addr_strap),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_all    (wr_all),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    dac_code_bank #(.NCH(NCH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_all  (wr_all),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .code_out(code_out)
    );

    // R1: the data line is released during reset recovery and while idle-high
    a_r1_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && sda_lvl && !$past(sda_oe)) |-> !sda_oe);

endmodule

// File: tb/sim_i2c_dac_regbank.sv
module sim_i2c_dac_regbank;
    localparam int NCH = 12;
    localparam int Q   = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic [2:0] strap = 3'b101;
    logic sda_oe;
    logic [NCH*8-1:0] code_out;
    wire  sda_line = sda_drv & ~sda_oe;

    int errs = 0;
    int checks = 0;
    bit finished = 0;
    int exp_c [NCH];
    int probe_ch = -1;
    int probe_val = 0;
    bit glitch_on = 0;

    always #2 clk = ~clk;

    i2c_dac_regbank #(.NCH(NCH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_drv),
        .sda_in    (sda_line),
        .addr_strap(strap),
        .sda_oe    (sda_oe),
        .code_out  (code_out)
    );

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int code_of(input int ch);
        return int'(code_out[ch*8 +: 8]);
    endfunction

    task automatic check_all(input string req);
        for (int ch = 0; ch < NCH; ch++) check(req, code_of(ch), exp_c[ch]);
    endtask

    task automatic bit_out(input logic b);
        sda_drv = b;
        if (glitch_on) begin
            wq(6); scl_drv = 1'b1; wq(10); scl_drv = 1'b0; wq(Q - 16);
            scl_drv = 1'b1; wq(8); sda_drv = ~b; wq(10); sda_drv = b; wq(2*Q - 18);
        end else begin
            wq(Q); scl_drv = 1'b1; wq(2*Q);
        end
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output int ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        ack = int'(sda_oe);
        if (probe_ch >= 0) begin
            check("R9 code updated by ack clock", code_of(probe_ch), probe_val);
            probe_ch = -1;
        end
        wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; wq(Q);
        scl_drv = 1'b1; wq(Q);
        sda_drv = 1'b1; wq(Q);
    endtask

    // header: START, address byte, selector byte; both acks compared to exp_ack
    task automatic header(input string req, input logic [7:0] ab, input logic [7:0] sel, input int exp_ack);
        int a;
        bus_start;
        send_byte(ab, a);
        check({req, " address ack"}, a, exp_ack);
        send_byte(sel, a);
        check({req, " selector ack"}, a, exp_ack);
    endtask

    task automatic data_byte(input string req, input logic [7:0] d, input int exp_ack);
        int a;
        send_byte(d, a);
        check({req, " data ack"}, a, exp_ack);
    endtask

    initial begin
        for (int ch = 0; ch < NCH; ch++) exp_c[ch] = 0;
        wq(10);
        // R1: reset state
        check("R1 sda_oe in reset", int'(sda_oe), 0);
        check_all("R1 reset code");
        rst_n = 1'b1;
        wq(50);
        check("R1 sda_oe after reset", int'(sda_oe), 0);

        // R4 + R9: each channel, odd channels with upper nibble set
        for (int k = 0; k < NCH; k++) begin
            logic [7:0] sel;
            int v;
            sel = 8'(k + 1) | ((k % 2 == 1) ? 8'hA0 : 8'h00);
            v = (k * 21 + 7) % 256;
            header("R4", 8'h9A, sel, 1);
            probe_ch = k; probe_val = v;
            data_byte("R4", 8'(v), 1);
            bus_stop;
            exp_c[k] = v;
        end
        check_all("R4 single channel sweep");

        // R5: extra bytes after single-channel write ignored
        header("R5", 8'h9A, 8'h03, 1);
        data_byte("R5", 8'hE1, 1);
        data_byte("R5", 8'h12, 1);
        data_byte("R5", 8'h34, 1);
        bus_stop;
        exp_c[2] = 8'hE1;
        check_all("R5 extra bytes ignored");

        // R6: broadcast, only the first byte
        header("R6", 8'h9A, 8'h70, 1);
        data_byte("R6", 8'h5A, 1);
        data_byte("R6", 8'h11, 1);
        bus_stop;
        for (int ch = 0; ch < NCH; ch++) exp_c[ch] = 8'h5A;
        check_all("R6 broadcast");

        // R7: stream with wrap (14 bytes)
        header("R7", 8'h9A, 8'h0F, 1);
        for (int k = 0; k < 14; k++) begin
            data_byte("R7", 8'((8'h80 + 3 * k) % 256), 1);
            exp_c[k % NCH] = (8'h80 + 3 * k) % 256;
        end
        bus_stop;
        check_all("R7 stream wrap");

        // R11: repeated START restarts stream at channel 1
        header("R11", 8'h9A, 8'hFF, 1);
        data_byte("R11", 8'h01, 1);
        data_byte("R11", 8'h02, 1);
        exp_c[0] = 1; exp_c[1] = 2;
        header("R11 restart", 8'h9A, 8'h0F, 1);
        data_byte("R11", 8'h77, 1);
        bus_stop;
        exp_c[0] = 8'h77;
        check_all("R11 stream restart");

        // R8: don't-care selectors
        header("R8", 8'h9A, 8'h0D, 1);
        data_byte("R8", 8'hCC, 1);
        bus_stop;
        header("R8", 8'h9A, 8'h3E, 1);
        data_byte("R8", 8'hDD, 1);
        bus_stop;
        check_all("R8 no change");

        // R3: read bit set, then whole frame ignored
        header("R3 read", 8'h9B, 8'h01, 0);
        data_byte("R3 read", 8'hEE, 0);
        bus_stop;
        // R3: upper bits wrong
        header("R3 upper", 8'h8A, 8'h00, 0);
        data_byte("R3 upper", 8'hEE, 0);
        bus_stop;
        check_all("R3 no change");

        // R2/R3: strap sweep
        for (int s = 0; s < 8; s++) begin
            int a;
            strap = 3'(s);
            bus_start;
            send_byte({4'b1001, 3'((s + 1) % 8), 1'b0}, a);
            check("R3 other strap nack", a, 0);
            bus_stop;
            header("R2 strap", {4'b1001, 3'(s), 1'b0}, 8'(s + 1), 1);
            data_byte("R2 strap", 8'(s * 17 + 3), 1);
            bus_stop;
            exp_c[s] = s * 17 + 3;
        end
        check_all("R2 strap sweep");

        // R10: glitches on both lines during a code byte
        strap = 3'b010;
        header("R10", 8'h94, 8'h05, 1);
        glitch_on = 1;
        data_byte("R10", 8'hC3, 1);
        glitch_on = 0;
        bus_stop;
        exp_c[4] = 8'hC3;
        check_all("R10 glitch filtered");

        wq(20);
        check("R1 idle release", int'(sda_oe), 0);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule